// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a synchronous host and an external asynchronous dual-port static RAM that also contains a separate semaphore region. The host hands over one word at a time with a request/ready handshake. Each word carries an address, data and three control bits: array versus semaphore target, strobe ordering, and whether the memory's output enable is held low during the write. The block then plays out the address, enable, read/write, output-enable and data-drive signals in an order the asynchronous part accepts.

Every memory-side signal comes straight from a flip-flop. Each interval is a whole number of clock cycles taken from a parameter, with a minimum of 1:

- address setup `T_AS`
- write pulse `T_WP`
- output turn-off `T_WZ`
- data setup `T_DW`
- data hold `T_DH`
- write recovery `T_WR`

Two pulse lengths are fixed at elaboration. The plain pulse is max(`T_WP`,`T_DW`). The stretched pulse is max(`T_WP`,`T_WZ`+`T_DW`) and is used when the memory's outputs could still be driving the shared pins.

In both ordering modes the two write strobes are released on the same edge. Recovery and data hold are counted from that edge. The host sees ready only after both have finished.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset `ready_o`=1, `mem_ce_no`=`mem_sem_no`=`mem_rw_no`=`mem_oe_no`=1 and `mem_dq_oe_o`=0. A request is accepted on a rising edge where `req_i`=1 and `ready_o`=1, and `ready_o` drops on that same edge.
- R2: On the acceptance edge, `mem_addr_o` takes `addr_i` and `mem_dq_o` takes `data_i`. Both stay unchanged until the next acceptance, so the address never moves while an enable and `mem_rw_no` are both low.
- R3: With `ce_mode_i`=0 (read/write-controlled), the selected enable falls on the acceptance edge and `mem_rw_no` falls `T_AS` cycles later.
- R4: With `ce_mode_i`=1 (enable-controlled), `mem_rw_no` falls on the acceptance edge and the selected enable falls `T_AS` cycles later.
- R5: With `sem_i`=0 only `mem_ce_no` is pulsed and `mem_sem_no` stays 1. With `sem_i`=1 only `mem_sem_no` is pulsed and `mem_ce_no` stays 1. The two are never low together.
- R6: The enable and `mem_rw_no` overlap low for max(`T_WP`,`T_DW`) cycles. The exception is `ce_mode_i`=0 with `oe_low_i`=1, where the overlap is max(`T_WP`,`T_WZ`+`T_DW`) cycles. Both strobes rise on the same edge.
- R7: With `ce_mode_i`=0 and `oe_low_i`=1, `mem_dq_oe_o` rises `T_WZ` cycles after `mem_rw_no` falls. In every other case it rises on the edge where the last strobe falls.
- R8: `mem_dq_oe_o` falls `T_DH` cycles after the strobes rise, and `mem_dq_o` stays constant while it is high.
- R9: `ready_o` returns max(`T_DH`,`T_WR`) cycles after the strobes rise. A request held or changed while busy is not taken until then, and it is taken on the first edge with `ready_o`=1.
- R10: With `oe_low_i`=1, `mem_oe_no` is 0 from the acceptance edge until the edge that raises `ready_o`. With `oe_low_i`=0 it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request |
| ready_o | output | 1 | Idle and able to accept a request |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| sem_i | input | 1 | 1 targets the semaphore region, 0 the array |
| ce_mode_i | input | 1 | 1 enable-controlled, 0 read/write-controlled |
| oe_low_i | input | 1 | Hold memory output enable low during the write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Array chip enable, active low |
| mem_sem_no | output | 1 | Semaphore enable, active low |
| mem_rw_no | output | 1 | Read/write, low writes |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Write data toward the memory pins |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |

## Verification
Writes are issued in each combination that changes the strobe timing:

- Array and semaphore targets show that only one enable pulses.
- Both ordering modes show which strobe falls last.
- Output enable low and high in read/write-controlled mode tell the stretched pulse and delayed data drive apart from the plain ones.
- Enable-controlled mode with output enable low shows that the stretch and the drive delay are skipped when the enable falls last.

A back-to-back run keeps the request high with a new address while the block is busy. It shows that the address holds through recovery and that the new request starts on the first ready edge.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_TAIL} wr_state_e;

  typedef struct packed {
    logic sem;      // 1: semaphore region
    logic ce_mode;  // 1: enable falls last
    logic oe_low;   // hold output enable low
  } wr_ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_req_latch.sv
module sram_wr_req_latch
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  wr_ctl_t           ctl_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output wr_ctl_t           ctl_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      ctl_o  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
      ctl_o  <= ctl_i;
    end
  end

endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int T_AS = 1,
  parameter int T_WP = 3,
  parameter int T_WZ = 2,
  parameter int T_DW = 2,
  parameter int T_DH = 1,
  parameter int T_WR = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  wr_ctl_t ctl_i,
  input  wr_ctl_t ctl_q_i,
  output logic    load_o,
  output logic    ready_o,
  output logic    ce_no,
  output logic    sem_no,
  output logic    rw_no,
  output logic    oe_no,
  output logic    dq_oe_o
);

  localparam int PLEN_PLAIN = imax(T_WP, T_DW);
  localparam int PLEN_GATE  = imax(T_WP, T_WZ + T_DW);
  localparam int TAIL_LEN   = imax(T_DH, T_WR);
  localparam int MAX_CNT    = imax(imax(PLEN_GATE, TAIL_LEN), T_AS);
  localparam int CW         = $clog2(MAX_CNT + 1);

  localparam logic [CW-1:0] AS_END   = CW'(T_AS - 1);
  localparam logic [CW-1:0] WZ_END   = CW'(T_WZ - 1);
  localparam logic [CW-1:0] PP_END   = CW'(PLEN_PLAIN - 1);
  localparam logic [CW-1:0] PG_END   = CW'(PLEN_GATE - 1);
  localparam logic [CW-1:0] DH_END   = CW'(T_DH - 1);
  localparam logic [CW-1:0] TAIL_END = CW'(TAIL_LEN - 1);

  wr_state_e     state;
  logic [CW-1:0] cnt;
  logic          gated;
  logic [CW-1:0] pulse_end;

  // I/O may still drive only when enable fell before R/W with OE low
  assign gated     = ~ctl_q_i.ce_mode & ctl_q_i.oe_low;
  assign pulse_end = gated ? PG_END : PP_END;
  assign load_o    = req_i & (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ready_o <= 1'b1;
      ce_no   <= 1'b1;
      sem_no  <= 1'b1;
      rw_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (req_i) begin
            ready_o <= 1'b0;
            oe_no   <= ~ctl_i.oe_low;
            if (ctl_i.ce_mode) begin
              rw_no <= 1'b0;
            end else begin
              ce_no  <= ctl_i.sem;
              sem_no <= ~ctl_i.sem;
            end
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == AS_END) begin
            cnt <= '0;
            if (ctl_q_i.ce_mode) begin
              ce_no  <= ctl_q_i.sem;
              sem_no <= ~ctl_q_i.sem;
            end else begin
              rw_no <= 1'b0;
            end
            if (!gated) dq_oe_o <= 1'b1;
            state <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (gated && cnt == WZ_END) dq_oe_o <= 1'b1;
          if (cnt == pulse_end) begin
            cnt    <= '0;
            ce_no  <= 1'b1;
            sem_no <= 1'b1;
            rw_no  <= 1'b1;
            state  <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (cnt == DH_END) dq_oe_o <= 1'b0;
          if (cnt == TAIL_END) begin
            ready_o <= 1'b1;
            oe_no   <= 1'b1;
            dq_oe_o <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  ce_sem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_no && !sem_no));

  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_no || !ce_no || !sem_no || dq_oe_o) |-> !ready_o);

  // R6
  joint_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rw_no) |-> (ce_no && sem_no));

  // R7
  drive_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (!rw_no && !(ce_no && sem_no)));

  // R8
  drive_off_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (rw_no && ce_no && sem_no));

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 9,
  parameter int T_AS   = 1,
  parameter int T_WP   = 3,
  parameter int T_WZ   = 2,
  parameter int T_DW   = 2,
  parameter int T_DH   = 1,
  parameter int T_WR   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sem_i,
  input  logic              ce_mode_i,
  input  logic              oe_low_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_sem_no,
  output logic              mem_rw_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  wr_ctl_t ctl_in, ctl_q;
  logic    load;

  assign ctl_in = '{sem: sem_i, ce_mode: ce_mode_i, oe_low: oe_low_i};

  sram_wr_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .data_i (data_i),
    .ctl_i  (ctl_in),
    .addr_o (mem_addr_o),
    .data_o (mem_dq_o),
    .ctl_o  (ctl_q)
  );

  sram_wr_fsm #(
    .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
    .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ctl_i   (ctl_in),
    .ctl_q_i (ctl_q),
    .load_o  (load),
    .ready_o (ready_o),
    .ce_no   (mem_ce_no),
    .sem_no  (mem_sem_no),
    .rw_no   (mem_rw_no),
    .oe_no   (mem_oe_no),
    .dq_oe_o (mem_dq_oe_o)
  );

  // R2
  addr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rw_no && !(mem_ce_no && mem_sem_no)) |-> $stable(mem_addr_o));

  // R8
  data_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> $stable(mem_dq_o));

endmodule

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;

  localparam int AW = 16, DW = 9;
  localparam int T_AS = 1, T_WP = 3, T_WZ = 2, T_DW = 2, T_DH = 1, T_WR = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, sem = 1'b0, mode = 1'b0, oel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          ready, ce_n, sem_n, rw_n, oe_n, dq_oe;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_dq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WZ(T_WZ),
                .T_DW(T_DW), .T_DH(T_DH), .T_WR(T_WR)) u_sram_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .addr_i(addr), .data_i(data), .sem_i(sem), .ce_mode_i(mode), .oe_low_i(oel),
    .mem_addr_o(m_addr), .mem_ce_no(ce_n), .mem_sem_no(sem_n), .mem_rw_no(rw_n),
    .mem_oe_no(oe_n), .mem_dq_o(m_dq), .mem_dq_oe_o(dq_oe)
  );

  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string req_tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    // R1 reset state
    check("R1", "ready after reset", int'(ready), 1);
    check("R1", "strobes idle after reset", int'({ce_n, sem_n, rw_n, oe_n}), 15);
    check("R1", "drive off after reset", int'(dq_oe), 0);
  endtask

  // One write; measures every edge index relative to the acceptance edge
  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic s, input logic m, input logic o);
    int en_fall = -1, rw_fall = -1, en_rise = -1, rw_rise = -1;
    int dq_rise = -1, dq_fall = -1, rdy = -1;
    int addr_bad = 0, data_bad = 0, oe_bad = 0, other_bad = 0, oe_end = 0;
    int late, plen, rise;
    logic en, oth;
    @(negedge clk);
    addr = a; data = d; sem = s; mode = m; oel = o; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check("R1", "ready drops on accept", int'(ready), 0);
    for (int k = 0; k < 64 && rdy < 0; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      en  = s ? sem_n : ce_n;
      oth = s ? ce_n : sem_n;
      if (!en && en_fall < 0) en_fall = k;
      if (en && en_fall >= 0 && en_rise < 0) en_rise = k;
      if (!rw_n && rw_fall < 0) rw_fall = k;
      if (rw_n && rw_fall >= 0 && rw_rise < 0) rw_rise = k;
      if (dq_oe && dq_rise < 0) dq_rise = k;
      if (!dq_oe && dq_rise >= 0 && dq_fall < 0) dq_fall = k;
      if (oth !== 1'b1) other_bad++;
      if (m_addr !== a) addr_bad++;
      if (dq_oe && m_dq !== d) data_bad++;
      if (ready) begin
        rdy = k;
        oe_end = int'(oe_n);
      end else if (oe_n !== ~o) oe_bad++;
    end
    late = T_AS;
    plen = (!m && o) ? bmax(T_WP, T_WZ + T_DW) : bmax(T_WP, T_DW);
    rise = late + plen;
    // R3 / R4 fall order
    check(m ? "R4" : "R3", "enable fall index", en_fall, m ? late : 0);
    check(m ? "R4" : "R3", "rw fall index", rw_fall, m ? 0 : late);
    // R6 overlap length and joint release
    check("R6", "enable rise index", en_rise, rise);
    check("R6", "rw rise index", rw_rise, rise);
    // R7 drive start
    check("R7", "drive rise index", dq_rise, (!m && o) ? late + T_WZ : late);
    // R8 drive end and data
    check("R8", "drive fall index", dq_fall, rise + T_DH);
    check("R8", "driven data mismatches", data_bad, 0);
    // R9 recovery
    check("R9", "ready return index", rdy, rise + bmax(T_DH, T_WR));
    // R2 address
    check("R2", "address mismatches", addr_bad, 0);
    // R5 other enable idle
    check("R5", "other enable low samples", other_bad, 0);
    // R10 output enable
    check("R10", "oe level mismatches", oe_bad, 0);
    check("R10", "oe released with ready", oe_end, 1);
  endtask

  task automatic back_to_back();
    int rdy = -1, held_bad = 0;
    @(negedge clk);
    addr = 16'h1111; data = 9'h055; sem = 1'b0; mode = 1'b0; oel = 1'b1; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addr = 16'h2222; data = 9'h1AA; sem = 1'b1; mode = 1'b1; oel = 1'b0;
    for (int k = 0; k < 64 && rdy < 0; k++) begin
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      if (m_addr !== 16'h1111 || sem_n !== 1'b1) held_bad++;
      if (ready) rdy = k;
    end
    // R9 busy request ignored
    check("R9", "busy request changed memory side", held_bad, 0);
    check("R9", "first ready index",
          rdy, T_AS + bmax(T_WP, T_WZ + T_DW) + bmax(T_DH, T_WR));
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    // R2 new address on first ready edge
    check("R2", "second address", int'(m_addr), 16'h2222);
    check("R9", "second request taken", int'(ready), 0);
    check("R4", "second rw low at accept", int'(rw_n), 0);
    for (int k = 0; k < 64 && !ready; k++) begin @(posedge clk); @(negedge clk); end
    check("R9", "ready after second write", int'(ready), 1);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_write(16'hA5A5, 9'h1C3, 1'b0, 1'b0, 1'b0);
    run_write(16'h0F0F, 9'h0A5, 1'b0, 1'b0, 1'b1);
    run_write(16'h0003, 9'h101, 1'b1, 1'b1, 1'b0);
    run_write(16'h0005, 9'h0FE, 1'b1, 1'b0, 1'b1);
    run_write(16'hFFFF, 9'h155, 1'b0, 1'b1, 1'b1);
    back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule